// File: doc/BRIEF.md
# Watchdog Timer with Grace-Delayed Reset

This block supervises software by counting system clocks from the last restart. The count passes through a fixed prescaler and then three cascaded divide-by-8 stages, and a 2-bit select chooses one of four tap points as the timeout. When the chosen tap expires, a sticky interrupt flag is set. The flag produces an interrupt request only when both its own enable and the global enable are set.

A separate reset-enable bit lets the timeout also start a fixed grace count. If software does not restart the watchdog before the grace count ends, the block drives a reset pulse of fixed length. It also records that the reset came from the watchdog in a status flag. This flag survives the watchdog's own reset, so software can read it afterwards. The interrupt path and the reset path are enabled independently. A restart writes a self-clearing bit, which clears the counter chain and cancels any pending grace count.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` is low at a clock edge, `irq_flag`, `wdrst_flag`, `wd_reset`, `irq` and `restart_bit` are all 0.
- R2: A one-cycle `restart_wr` pulse makes `restart_bit` read 1 for exactly one cycle and then 0 without further writes. The counter chain restarts from zero on the edge after `restart_bit` reads 1.
- R3: With `int_sel` = 0, 1, 2, 3, `irq_flag` rises 2^P, 2^(P+S), 2^(P+2S) or 2^(P+3S) clocks after the counter clears. P is `PRESCALE_BITS` and S is `STAGE_BITS` (default 17 and 3, giving 2^17, 2^20, 2^23 and 2^26).
- R4: `irq_flag` stays set until `flag_clr` is asserted or a watchdog reset pulse starts. If a timeout and `flag_clr` fall on the same edge, the timeout wins.
- R5: `irq` is 1 only when `irq_flag`, `wd_ie` and `glob_ie` are all 1.
- R6: With `rst_en` = 1, `wd_reset` rises `GRACE_CYCLES` clocks after the edge that set `irq_flag` (default 512). It stays high for `PULSE_CYCLES` clocks (default 4). With `rst_en` = 0, no reset pulse occurs.
- R7: A restart or a drop of `rst_en` during the grace count cancels the pending reset.
- R8: The start of a reset pulse sets `wdrst_flag` and clears `irq_flag` and the counter chain. `wdrst_flag` is cleared only by `rsflag_clr` or by `rst_n`, not by a later watchdog reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| restart_wr | input | 1 | Write of 1 to the restart bit |
| rst_en | input | 1 | Enable for the delayed reset path |
| int_sel | input | 2 | Timeout tap select (0 shortest, 3 longest) |
| wd_ie | input | 1 | Watchdog interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| flag_clr | input | 1 | Clears the interrupt flag |
| rsflag_clr | input | 1 | Clears the watchdog-reset status flag |
| restart_bit | output | 1 | Read-back of the self-clearing restart bit |
| irq_flag | output | 1 | Sticky timeout flag |
| wdrst_flag | output | 1 | Status: last reset came from the watchdog |
| irq | output | 1 | Interrupt request |
| wd_reset | output | 1 | Reset pulse to the system |

## Verification
The hardest state to reach is the middle of the grace count. There a restart or a drop of the reset enable must cancel a reset that is already scheduled. Reaching it requires a full timeout with the reset path armed, which is very long at the default sizes. The bench therefore shrinks the prescaler, stage widths and grace length through parameters. It then selects the longest tap so that no second timeout can start a new grace count. Finally it places the restart or enable drop a few cycles after the flag rises and watches for a whole grace window with no pulse.

// File: rtl/wdt_pkg.sv
// Package: shared sizes and types for the watchdog timer.
// Assumes exactly four timeout taps, selected by a 2-bit field.
package wdt_pkg;
    localparam int NUM_TAPS = 4;
    typedef logic [1:0] tap_sel_t;
endpackage

// File: rtl/wdt_divstage.sv
// One divider stage of the watchdog counter chain.
// Counts while en is high and emits carry on the cycle that wraps it.
// Assumes clr has priority over counting.
module wdt_divstage #(
    parameter int W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic carry
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] cnt;

    // Count enabled ticks and clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (en)       cnt <= cnt + 1'b1;
    end

    assign carry = en && (cnt == ALL_ONES);
endmodule

// File: rtl/wdt_grace.sv
// Grace-delay counter and reset-pulse generator.
// start arms the grace count. abort cancels it. After GRACE cycles a
// reset pulse of PULSE cycles is driven, and fire marks its first edge.
// Assumes GRACE >= 2 and PULSE >= 1.
module wdt_grace #(
    parameter int GRACE = 512,
    parameter int PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic fire,
    output logic pulse
);
    localparam int GW = $clog2(GRACE + 1);
    localparam int PW = $clog2(PULSE + 1);
    localparam logic [GW-1:0] G_LAST = GW'(GRACE - 1);
    localparam logic [PW-1:0] P_LEN  = PW'(PULSE);

    logic          active;
    logic [GW-1:0] gcnt;
    logic [PW-1:0] pcnt;

    assign fire  = active && !abort && (gcnt == G_LAST);
    assign pulse = (pcnt != '0);

    // Run the grace count from arm until fire or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active <= 1'b0;
            gcnt   <= '0;
        end else if (fire) begin
            active <= 1'b0;
            gcnt   <= '0;
        end else if (active) begin
            gcnt <= gcnt + 1'b1;
        end else if (start) begin
            active <= 1'b1;
            gcnt   <= '0;
        end
    end

    // Hold the reset output for PULSE cycles after fire.
    always_ff @(posedge clk) begin
        if (!rst_n)       pcnt <= '0;
        else if (fire)    pcnt <= P_LEN;
        else if (pulse)   pcnt <= pcnt - 1'b1;
    end
endmodule

// File: rtl/wdog_timer.sv
// Watchdog timer top. A prescaler plus cascaded divider stages produce
// four taps, and the selected tap sets a sticky interrupt flag. An armed
// reset path fires a reset pulse after a grace delay.
// Assumes the control inputs come from synchronous register writes.
module wdog_timer #(
    parameter int PRESCALE_BITS = 17,
    parameter int STAGE_BITS    = 3,
    parameter int GRACE_CYCLES  = 512,
    parameter int PULSE_CYCLES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_wr,
    input  logic                 rst_en,
    input  wdt_pkg::tap_sel_t    int_sel,
    input  logic                 wd_ie,
    input  logic                 glob_ie,
    input  logic                 flag_clr,
    input  logic                 rsflag_clr,
    output logic                 restart_bit,
    output logic                 irq_flag,
    output logic                 wdrst_flag,
    output logic                 irq,
    output logic                 wd_reset
);
    localparam int NT = wdt_pkg::NUM_TAPS;

    logic [NT-1:0] carry;
    logic          chain_clr;
    logic          timeout;
    logic          fire;

    // Latch the restart write, clearing itself on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) restart_bit <= 1'b0;
        else        restart_bit <= restart_wr;
    end

    assign chain_clr = restart_bit || fire;

    genvar k;
    generate
        for (k = 0; k < NT; k++) begin : g_stage
            if (k == 0) begin : g_pre
                wdt_divstage #(.W(PRESCALE_BITS)) u_div (
                    .clk(clk), .rst_n(rst_n), .en(1'b1),
                    .clr(chain_clr), .carry(carry[k])
                );
            end else begin : g_oct
                wdt_divstage #(.W(STAGE_BITS)) u_div (
                    .clk(clk), .rst_n(rst_n), .en(carry[k-1]),
                    .clr(chain_clr), .carry(carry[k])
                );
            end
        end
    endgenerate

    assign timeout = carry[int_sel] && !chain_clr;

    wdt_grace #(.GRACE(GRACE_CYCLES), .PULSE(PULSE_CYCLES)) u_grace (
        .clk(clk), .rst_n(rst_n),
        .start(timeout && rst_en),
        .abort(restart_bit || !rst_en),
        .fire(fire), .pulse(wd_reset)
    );

    // Sticky interrupt flag: set on timeout, cleared by software or reset start.
    always_ff @(posedge clk) begin
        if (!rst_n || fire) irq_flag <= 1'b0;
        else if (timeout)   irq_flag <= 1'b1;
        else if (flag_clr)  irq_flag <= 1'b0;
    end

    // Reset-cause flag: set by a watchdog reset, cleared by software or power-on.
    always_ff @(posedge clk) begin
        if (!rst_n)          wdrst_flag <= 1'b0;
        else if (fire)       wdrst_flag <= 1'b1;
        else if (rsflag_clr) wdrst_flag <= 1'b0;
    end

    assign irq = irq_flag && wd_ie && glob_ie;
endmodule

// File: rtl/wdog_timer_chk.sv
// Checker for wdog_timer, bound to every instance.
module wdog_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic restart_wr,
    input logic rst_en,
    input logic flag_clr,
    input logic restart_bit,
    input logic irq_flag,
    input logic wdrst_flag,
    input logic irq,
    input logic wd_reset
);
    AST_RESTART_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_wr |=> !restart_bit); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> ($past(flag_clr) || wd_reset)); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag); // R5
    AST_RESET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset) |-> $past(rst_en)); // R6
    AST_RESTART_BLOCKS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        restart_bit && !wd_reset |=> !wd_reset); // R7
    AST_RESET_MARKS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset) |-> (wdrst_flag && !irq_flag)); // R8
endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .restart_wr(restart_wr), .rst_en(rst_en),
    .flag_clr(flag_clr), .restart_bit(restart_bit), .irq_flag(irq_flag),
    .wdrst_flag(wdrst_flag), .irq(irq), .wd_reset(wd_reset)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    localparam int P  = 4;
    localparam int S  = 2;
    localparam int G  = 40;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart_wr = 1'b0, rst_en = 1'b0, wd_ie = 1'b0, glob_ie = 1'b0;
    logic flag_clr = 1'b0, rsflag_clr = 1'b0;
    logic [1:0] int_sel = 2'd0;
    logic restart_bit, irq_flag, wdrst_flag, irq, wd_reset;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    wdog_timer #(.PRESCALE_BITS(P), .STAGE_BITS(S), .GRACE_CYCLES(G),
                 .PULSE_CYCLES(PL)) uut (
        .clk(clk), .rst_n(rst_n), .restart_wr(restart_wr), .rst_en(rst_en),
        .int_sel(int_sel), .wd_ie(wd_ie), .glob_ie(glob_ie),
        .flag_clr(flag_clr), .rsflag_clr(rsflag_clr),
        .restart_bit(restart_bit), .irq_flag(irq_flag),
        .wdrst_flag(wdrst_flag), .irq(irq), .wd_reset(wd_reset)
    );

    // vector: sel, rst_en, wd_ie, glob_ie, expected irq
    typedef struct packed {
        logic [1:0] sel;
        logic       ren;
        logic       ie;
        logic       gie;
        logic       exp_irq;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0},
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // restart and clear the flag; leaves us just after the clearing edge
    task automatic restart_clean();
        restart_wr = 1'b1; flag_clr = 1'b1;
        step();
        restart_wr = 1'b0;
        step();
        flag_clr = 1'b0;
    endtask

    task automatic wait_flag(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            step();
            if (irq_flag) begin n = i; break; end
        end
    endtask

    task automatic wait_rst(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            step();
            if (wd_reset) begin n = i; break; end
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, len, seen;
        step(); step();
        // R1 reset state
        chk("R1 irq_flag", irq_flag, 0);
        chk("R1 wdrst_flag", wdrst_flag, 0);
        chk("R1 wd_reset", wd_reset, 0);
        chk("R1 irq", irq, 0);
        chk("R1 restart_bit", restart_bit, 0);
        rst_n = 1'b1;
        step();

        // R2 self-clearing restart bit
        restart_wr = 1'b1;
        step();
        restart_wr = 1'b0;
        chk("R2 restart_bit set", restart_bit, 1);
        step();
        chk("R2 restart_bit cleared", restart_bit, 0);

        foreach (VECS[v]) begin
            int_sel = VECS[v].sel; rst_en = VECS[v].ren;
            wd_ie = VECS[v].ie; glob_ie = VECS[v].gie;
            restart_clean();
            wait_flag(5000, n);
            chk("R3 interval", n, 1 << (P + S * int'(VECS[v].sel)));
            chk("R5 irq gating", irq, int'(VECS[v].exp_irq));
            if (VECS[v].ren) begin
                wait_rst(G + 10, n);
                chk("R6 grace delay", n, G);
                chk("R8 wdrst_flag set", wdrst_flag, 1);
                chk("R8 irq_flag cleared", irq_flag, 0);
                len = 1;
                while (wd_reset && len < 20) begin step(); if (wd_reset) len++; end
                chk("R6 pulse length", len, PL);
                rst_en = 1'b0;
                step();
                rsflag_clr = 1'b1; step(); rsflag_clr = 1'b0; step();
                chk("R8 rsflag_clr clears", wdrst_flag, 0);
            end else begin
                seen = 0;
                for (int i = 0; i < G + 10; i++) begin step(); if (wd_reset) seen = 1; end
                chk("R6 no reset when disabled", seen, 0);
                chk("R4 flag sticky", irq_flag, 1);
            end
        end

        // R4 set wins over clear: flag_clr held across the timeout edge
        int_sel = 2'd0; rst_en = 1'b0;
        restart_clean();
        for (int i = 1; i < 16; i++) step();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R4 timeout beats clear", irq_flag, 1);
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
        chk("R4 flag_clr clears", irq_flag, 0);

        // R7 restart during grace cancels reset
        int_sel = 2'd3; rst_en = 1'b1;
        restart_clean();
        wait_flag(5000, n);
        for (int i = 0; i < 10; i++) step();
        restart_wr = 1'b1; step(); restart_wr = 1'b0;
        seen = 0;
        for (int i = 0; i < G + 20; i++) begin step(); if (wd_reset) seen = 1; end
        chk("R7 restart cancels reset", seen, 0);

        // R7 dropping rst_en during grace cancels reset
        restart_clean();
        wait_flag(5000, n);
        for (int i = 0; i < 10; i++) step();
        rst_en = 1'b0; step(); step(); rst_en = 1'b1;
        seen = 0;
        for (int i = 0; i < G + 20; i++) begin step(); if (wd_reset) seen = 1; end
        chk("R7 enable drop cancels reset", seen, 0);

        // R8 flag survives a second watchdog reset; power-on reset clears it
        rst_en = 1'b1; int_sel = 2'd0;
        restart_clean();
        wait_flag(5000, n);
        wait_rst(G + 10, n);
        for (int i = 0; i < PL + 2; i++) step();
        wait_flag(5000, n);
        wait_rst(G + 10, n);
        chk("R8 second pulse", wd_reset, 1);
        chk("R8 flag kept across reset", wdrst_flag, 1);
        rst_en = 1'b0;
        rst_n = 1'b0; step(); rst_n = 1'b1;
        chk("R8 power-on clears flag", wdrst_flag, 0);
        chk("R1 reset output after rst_n", wd_reset, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule